// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Register

This block is a write-only I2C target that holds the settings of a tuner frequency synthesizer and its four band-select outputs. SCL and SDA arrive as raw pin levels and are resampled by a fast system clock. The block pulls SDA low through an open-drain output when it acknowledges. A two-bit strap input fills the low bits of the target address, so up to four of these blocks can share one bus.

After a matching address with the write direction, the data bytes are taken two at a time. The top bit of the first byte in each pair picks its role. A clear top bit starts a divider pair, which carries a 10-bit main ratio and a 5-bit swallow ratio. A set top bit starts a control pair, made of a control byte and a band byte. A pair reaches the output registers only after its second byte has arrived. A transfer cut short by STOP or by a repeated START therefore leaves the last committed values in place. Once a pair is committed, the next byte is classified again, so one transfer can write both groups in either order.

The bus side has no stream. Every output is a plain level that holds until the next committed pair of its group.

Top module: `tuner_pll_ctrl`

## Requirements
- R1: The block acknowledges an address byte equal to binary 1,1,0,0,0,S1,S0,0, where S1 S0 is `hw_sel` and the last bit is the direction (0 = write). It acknowledges by holding `sda_pull` high through the ninth SCL clock.
- R2: If the address bits differ from `hw_sel`, or the direction bit is 1, the block gives no acknowledge. It then ignores every byte until the next START, and its outputs do not change.
- R3: A data pair whose first byte has bit 7 = 0 sets `main_div` to {first[6:0], second[7:5]} and `swallow` to second[4:0].
- R4: A data pair whose first byte has bit 7 = 1 is a control pair. In the control byte, bit 6 drives `pump_hi`, bit 5 drives `gain_low`, bit 4 set to 1 clears `pump_en`, bits 2:1 drive `ref_sel`, bit 0 drives `vt_off`, and bit 3 is ignored. The band byte's bits 3:0 drive `band[3:0]`, and its upper bits are ignored.
- R5: Neither group changes on the first byte of its pair. A transfer that ends after one byte of a pair leaves both groups as they were.
- R6: After reset, `main_div`, `swallow` and `band` are zero, `pump_en` is 1, and `pump_hi`, `gain_low`, `vt_off` and `ref_sel` are 0.
- R7: After a committed pair, the next byte is classified again by its bit 7. One transfer can therefore write both groups in either order.
- R8: A repeated START begins a new address phase without a STOP. Any half-received pair from before it is dropped.
- R9: After a matched address, every data byte is acknowledged. The block releases `sda_pull` on the falling SCL edge that ends the acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level (wired line) |
| sda_pull | output | 1 | 1 = pull SDA low (open-drain drive) |
| hw_sel | input | 2 | Strap bits for the two low address bits |
| main_div | output | 10 | Main divide ratio |
| swallow | output | 5 | Swallow counter ratio |
| pump_en | output | 1 | Charge pump enabled |
| pump_hi | output | 1 | High charge-pump current selected |
| gain_low | output | 1 | Reduced gain selected |
| vt_off | output | 1 | Varicap drive output disabled |
| ref_sel | output | 2 | Reference divider ratio code |
| band | output | 4 | Band-switch outputs, 1 = on |

## Verification
A wrong pair-tracking state shows up at the ports in two ways. A divider value can land in the band outputs, or a half pair can be committed. Both are visible on the outputs within a few system clocks after the relevant eighth SCL rise. A wrong address decision shows on `sda_pull` during the very next acknowledge clock, long before any output could move. The stimulus therefore covers:
- pairs in both orders;
- truncated pairs;
- a repeated START in the middle of a pair;
- foreign and read addresses.

After each of these, the bench compares all outputs with a model kept in the bench.

// File: rtl/tpll_pkg.sv
package tpll_pkg;

  // bit-level receiver phases
  typedef enum logic [1:0] {
    RX_IDLE,
    RX_SHIFT,
    RX_WAIT_ACK,
    RX_ACK
  } rx_state_e;

  // which half of a data pair is expected next
  typedef enum logic [1:0] {
    PR_FIRST,
    PR_DIV,
    PR_CTRL
  } pair_state_e;

  // committed control settings, bit order as seen on the bus
  typedef struct packed {
    logic       cp;
    logic       gc;
    logic       cd;
    logic [1:0] ref_sel;
    logic       os;
  } ctrl_t;

endpackage

// File: rtl/tpll_line_sync.sv
module tpll_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  // idle bus level is high for both lines
  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;
  logic              scl_lvl;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_q[g] <= 1'b1;
          sda_q[g] <= 1'b1;
        end else begin
          scl_q[g] <= (g == 0) ? scl_in : scl_q[(g == 0) ? 0 : g-1];
          sda_q[g] <= (g == 0) ? sda_in : sda_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_q[STAGES-1];
  assign sda_lvl = sda_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_lvl;
      sda_d <= sda_lvl;
    end
  end

  assign scl_rise   = scl_lvl & ~scl_d;
  assign scl_fall   = ~scl_lvl & scl_d;
  assign start_seen = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_seen  = scl_lvl & scl_d & ~sda_d & sda_lvl;

endmodule

// File: rtl/tpll_byte_rx.sv
module tpll_byte_rx
  import tpll_pkg::*;
#(
  parameter int              SEL_W       = 2,
  parameter int              PREFIX_W    = 5,
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_lvl,
  input  logic             start_seen,
  input  logic             stop_seen,
  input  logic [SEL_W-1:0] hw_sel,
  output logic             sda_pull,
  output logic             addr_hit,
  output logic             byte_vld,
  output logic [7:0]       byte_data
);
  localparam int ADDR_W = PREFIX_W + SEL_W;
  localparam int CNT_W  = 4;

  rx_state_e        state;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic [7:0]       next_byte;
  logic             in_addr;
  logic             matched;

  assign next_byte = {shreg[6:0], sda_lvl};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      in_addr   <= 1'b0;
      matched   <= 1'b0;
      sda_pull  <= 1'b0;
      addr_hit  <= 1'b0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
    end else begin
      addr_hit <= 1'b0;
      byte_vld <= 1'b0;
      if (start_seen) begin
        state    <= RX_SHIFT;
        bit_cnt  <= '0;
        in_addr  <= 1'b1;
        matched  <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_seen) begin
        state    <= RX_IDLE;
        matched  <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        unique case (state)
          RX_SHIFT: begin
            if (scl_rise) begin
              shreg <= next_byte;
              if (bit_cnt == CNT_W'(7)) begin
                bit_cnt <= '0;
                if (in_addr) begin
                  if (next_byte[7:1] == ADDR_W'({ADDR_PREFIX, hw_sel}) && !next_byte[0]) begin
                    matched  <= 1'b1;
                    addr_hit <= 1'b1;
                    state    <= RX_WAIT_ACK;
                  end else begin
                    state <= RX_IDLE;
                  end
                end else begin
                  byte_vld  <= 1'b1;
                  byte_data <= next_byte;
                  state     <= RX_WAIT_ACK;
                end
              end else begin
                bit_cnt <= bit_cnt + CNT_W'(1);
              end
            end
          end
          RX_WAIT_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b1;
              state    <= RX_ACK;
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              sda_pull <= 1'b0;
              in_addr  <= 1'b0;
              state    <= RX_SHIFT;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_ACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> matched); // R2
  AST_DATA_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> matched); // R2
  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sda_pull) && !$past(start_seen) && !$past(stop_seen)) |-> $past(scl_fall)); // R9
  AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (in_addr && bit_cnt == '0 && !sda_pull)); // R8

endmodule

// File: rtl/tpll_pair_sorter.sv
module tpll_pair_sorter
  import tpll_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SW_W   = 5,
  parameter int BAND_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_hit,
  input  logic              byte_vld,
  input  logic [7:0]        byte_data,
  output logic [DIV_W-1:0]  main_div,
  output logic [SW_W-1:0]   swallow,
  output ctrl_t             ctrl,
  output logic [BAND_N-1:0] band
);
  // first byte carries the role flag plus the top 7 ratio bits
  localparam int HI_BITS = 7;
  localparam int LO_BITS = DIV_W - HI_BITS;

  pair_state_e st;
  logic [7:0]  hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= PR_FIRST;
      hold     <= '0;
      main_div <= '0;
      swallow  <= '0;
      ctrl     <= '0;
      band     <= '0;
    end else if (addr_hit) begin
      st <= PR_FIRST;
    end else if (byte_vld) begin
      unique case (st)
        PR_FIRST: begin
          hold <= byte_data;
          st   <= byte_data[7] ? PR_CTRL : PR_DIV;
        end
        PR_DIV: begin
          main_div <= {hold[HI_BITS-1:0], byte_data[7 -: LO_BITS]};
          swallow  <= byte_data[SW_W-1:0];
          st       <= PR_FIRST;
        end
        PR_CTRL: begin
          ctrl <= '{cp: hold[6], gc: hold[5], cd: hold[4],
                    ref_sel: hold[2:1], os: hold[0]};
          band <= byte_data[BAND_N-1:0];
          st   <= PR_FIRST;
        end
        default: st <= PR_FIRST;
      endcase
    end
  end

  AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> ($stable(main_div) && $stable(swallow))); // R5
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> ($stable(ctrl) && $stable(band))); // R5
  AST_DIV_SECOND_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(main_div) |-> $past(st) == PR_DIV); // R3
  AST_BAND_SECOND_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(band) |-> $past(st) == PR_CTRL); // R4

endmodule

// File: rtl/tuner_pll_ctrl.sv
module tuner_pll_ctrl
  import tpll_pkg::*;
#(
  parameter int DIV_W  = 10,
  parameter int SW_W   = 5,
  parameter int BAND_N = 4,
  parameter int SEL_W  = 2,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  input  logic [SEL_W-1:0]  hw_sel,
  output logic [DIV_W-1:0]  main_div,
  output logic [SW_W-1:0]   swallow,
  output logic              pump_en,
  output logic              pump_hi,
  output logic              gain_low,
  output logic              vt_off,
  output logic [1:0]        ref_sel,
  output logic [BAND_N-1:0] band
);
  logic       sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
  logic       addr_hit, byte_vld;
  logic [7:0] byte_data;
  ctrl_t      ctrl;

  tpll_line_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  tpll_byte_rx #(.SEL_W(SEL_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_lvl(sda_lvl), .start_seen(start_seen), .stop_seen(stop_seen),
    .hw_sel(hw_sel), .sda_pull(sda_pull), .addr_hit(addr_hit),
    .byte_vld(byte_vld), .byte_data(byte_data)
  );

  tpll_pair_sorter #(.DIV_W(DIV_W), .SW_W(SW_W), .BAND_N(BAND_N)) u_sort (
    .clk(clk), .rst_n(rst_n), .addr_hit(addr_hit), .byte_vld(byte_vld),
    .byte_data(byte_data), .main_div(main_div), .swallow(swallow),
    .ctrl(ctrl), .band(band)
  );

  assign pump_en  = ~ctrl.cd;
  assign pump_hi  = ctrl.cp;
  assign gain_low = ctrl.gc;
  assign vt_off   = ctrl.os;
  assign ref_sel  = ctrl.ref_sel;

  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (main_div == '0 && swallow == '0 && band == '0 && pump_en)); // R6

endmodule

// File: tb/sim_tuner_pll_ctrl.sv
module sim_tuner_pll_ctrl;
  localparam int Q = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic [1:0] hw_sel = 2'b01;
  logic       sda_pull;
  wire        sda_line = sda_drv & ~sda_pull;
  logic [9:0] main_div;
  logic [4:0] swallow;
  logic       pump_en, pump_hi, gain_low, vt_off;
  logic [1:0] ref_sel;
  logic [3:0] band;

  tuner_pll_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
    .sda_pull(sda_pull), .hw_sel(hw_sel), .main_div(main_div),
    .swallow(swallow), .pump_en(pump_en), .pump_hi(pump_hi),
    .gain_low(gain_low), .vt_off(vt_off), .ref_sel(ref_sel), .band(band)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  // bench model of committed state
  logic [9:0] m_div = '0;
  logic [4:0] m_sw = '0;
  logic [7:0] m_ctl = '0;
  logic [3:0] m_band = '0;

  logic [24:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [24:0] model_vec();
    return {m_div, m_sw, ~m_ctl[4], m_ctl[6], m_ctl[5], m_ctl[0], m_ctl[2:1], m_band};
  endfunction

  task automatic push_exp(input string tag);
    exp_q.push_back(model_vec());
    tag_q.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit acked;
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(Q);
      scl_drv = 1'b1; tick(Q);
      scl_drv = 1'b0; tick(Q);
    end
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q/2);
    acked = (sda_line == 1'b0);
    tick(Q/2);
    scl_drv = 1'b0; tick(Q);
    checks++;
    if (acked !== exp_ack) begin
      errs++;
      $display("FAIL %s: ack on byte %h actual=%0b expected=%0b", tag, b, acked, exp_ack);
    end
  endtask

  // monitor: pops expectations and compares the outputs
  initial begin
    forever begin
      logic [24:0] e, a;
      string t;
      wait (exp_q.size() > 0);
      @(negedge clk);
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {main_div, swallow, pump_en, pump_hi, gain_low, vt_off, ref_sel, band};
      checks++;
      if (a !== e) begin
        errs++;
        $display("FAIL %s: outputs actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: run did not complete (all requirements)");
    finish_run();
  end

  initial begin
    tick(5); rst_n = 1'b1; tick(5);
    push_exp("R6 reset values");

    // control pair, strap 01
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'hD5, 1'b1, "R9 control byte ack");
    send_byte(8'hFA, 1'b1, "R9 band byte ack");
    bus_stop();
    m_ctl = 8'hD5; m_band = 4'hA;
    push_exp("R4 control pair");

    // short divider-only write
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'h5A, 1'b1, "R9 divider byte ack");
    send_byte(8'hB3, 1'b1, "R9 divider byte ack");
    bus_stop();
    m_div = 10'h2D5; m_sw = 5'h13;
    push_exp("R3 divider pair");

    // truncated divider pair
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'h12, 1'b1, "R9 ack");
    bus_stop();
    push_exp("R5 half divider pair dropped");

    // truncated control pair
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'h80, 1'b1, "R9 ack");
    bus_stop();
    push_exp("R5 half control pair dropped");

    // foreign address
    bus_start();
    send_byte(8'hC4, 1'b0, "R2 foreign address no ack");
    send_byte(8'h11, 1'b0, "R2 ignored byte no ack");
    send_byte(8'h22, 1'b0, "R2 ignored byte no ack");
    bus_stop();
    push_exp("R2 outputs unchanged after foreign address");

    // read direction
    bus_start();
    send_byte(8'hC3, 1'b0, "R2 read direction no ack");
    bus_stop();
    push_exp("R2 outputs unchanged after read address");

    // control then divider in one transfer
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'hA6, 1'b1, "R9 ack");
    send_byte(8'h05, 1'b1, "R9 ack");
    send_byte(8'h33, 1'b1, "R9 ack");
    send_byte(8'h4F, 1'b1, "R9 ack");
    bus_stop();
    m_ctl = 8'hA6; m_band = 4'h5; m_div = 10'h19A; m_sw = 5'h0F;
    push_exp("R7 control then divider");

    // divider then control in one transfer
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'h01, 1'b1, "R9 ack");
    send_byte(8'hE0, 1'b1, "R9 ack");
    send_byte(8'hC8, 1'b1, "R9 ack");
    send_byte(8'hF3, 1'b1, "R9 ack");
    bus_stop();
    m_div = 10'h00F; m_sw = 5'h00; m_ctl = 8'hC8; m_band = 4'h3;
    push_exp("R7 divider then control");

    // repeated start in the middle of a pair
    bus_start();
    send_byte(8'hC2, 1'b1, "R1 address match");
    send_byte(8'h7F, 1'b1, "R9 ack");
    bus_start();
    send_byte(8'hC2, 1'b1, "R8 address after repeated start");
    send_byte(8'h22, 1'b1, "R9 ack");
    send_byte(8'h64, 1'b1, "R9 ack");
    bus_stop();
    m_div = 10'h113; m_sw = 5'h04;
    push_exp("R8 repeated start new pair");

    // different strap value
    hw_sel = 2'b10;
    tick(4);
    bus_start();
    send_byte(8'hC2, 1'b0, "R2 old strap address no ack");
    bus_stop();
    bus_start();
    send_byte(8'hC4, 1'b1, "R1 strap 10 address match");
    send_byte(8'h90, 1'b1, "R9 ack");
    send_byte(8'h00, 1'b1, "R9 ack");
    bus_stop();
    m_ctl = 8'h90; m_band = 4'h0;
    push_exp("R1 R4 pump disabled under strap 10");

    wait (exp_q.size() == 0);
    tick(4);
    finish_run();
  end

endmodule